// File: doc/BRIEF.md
# Modulo Loop Branch Controller

This block decides the closing branch of a software-pipelined counted loop. It keeps two down-counters. The first is a kernel counter that counts the source iterations still to be started. The second is a drain counter that counts the extra passes the pipeline needs to empty. Each time the loop branch executes, the block chooses whether the branch is taken and produces the stage-enable bit for the rotating predicate bank. While new iterations are still being started, this bit is 1. While the pipeline drains, it is 0. Because of this bit, the fill and drain phases of the loop need no separate code.

The controller also raises a rotate strobe for every branch execution, including the last one. It does not hold the rotating predicate or register storage. It only reports when a rotation must happen. A load strobe starts a new loop by setting both counters. For a trip count N on a pipeline of S stages, software loads N-1 into the kernel counter and S into the drain counter. A done flag tells when the loop has exited.

Top module: `mlb_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `kc_o`, `dc_o`, `taken_o`, `stage_en_o`, `rotate_o` and `done_o` are all 0.
- R2: When `load_i` is high at a rising clock edge, `kc_o` equals `kc_init_i` and `dc_o` equals `dc_init_i` in the next cycle, and `done_o` is 0.
- R3: A branch (`br_i` high, `load_i` low) with `kc_o` nonzero makes `kc_o` one lower and leaves `dc_o` unchanged. In the next cycle it gives `stage_en_o`=1 and `taken_o`=1.
- R4: A branch with `kc_o`=0 and `dc_o` greater than 1 makes `dc_o` one lower and gives `stage_en_o`=0 and `taken_o`=1.
- R5: A branch with `kc_o`=0 and `dc_o`=1 brings `dc_o` to 0 and gives `stage_en_o`=0 and `taken_o`=0, which is the fall-through.
- R6: A branch with both counters at 0 leaves both at 0, so neither counter wraps. It gives `stage_en_o`=0 and `taken_o`=0.
- R7: `rotate_o` is high for exactly the one cycle after each branch, and that is the cycle in which `taken_o` and `stage_en_o` are valid. In every other cycle `rotate_o`, `taken_o` and `stage_en_o` are 0.
- R8: When `load_i` and `br_i` are both high, the load wins. The counters take the load values and no rotate pulse, predicate or taken result appears.
- R9: `done_o` goes high in the same cycle as a fall-through result (`rotate_o`=1, `taken_o`=0). It stays high through further branches until the next load.
- R10: After a load with kernel count 4 and drain count 3, seven branches give `kc_o` of 3,2,1,0,0,0,0 and `dc_o` of 3,3,3,3,2,1,0 after each branch. The first six are taken and the seventh falls through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load both counters from the init inputs |
| kc_init_i | input | CW | Initial kernel counter value (N-1) |
| dc_init_i | input | CW | Initial drain counter value (S) |
| br_i | input | 1 | Loop branch executes this cycle |
| taken_o | output | 1 | Branch taken (valid while rotate_o is high) |
| stage_en_o | output | 1 | Bit to write into the predicate bank before rotation |
| rotate_o | output | 1 | One-cycle request to rotate the register and predicate files |
| kc_o | output | CW | Current kernel counter |
| dc_o | output | CW | Current drain counter |
| done_o | output | 1 | Loop has fallen through since the last load |

## Verification
The bench loads every pair of kernel counts 0 to 5 and drain counts 0 to 4, then runs branches until the fall-through and one branch past it. A design that checked the wrong counter first, or that ended the loop one pass early or late, would show the wrong stage bit or a misplaced fall-through in this sweep. The extra branch after the exit catches a counter that wraps to all ones, which would restart the loop. Separate cases check that a load wins over a simultaneous branch (a wrong design would rotate or decrement), that branches issued back to back give one rotate pulse each, and that done holds until the next load.

// File: rtl/mlb_pkg.sv
package mlb_pkg;

    // Phase the loop is in when a branch executes
    typedef enum logic [1:0] {
        PH_KERNEL = 2'd0,   // source iterations still starting
        PH_DRAIN  = 2'd1,   // pipeline emptying, more passes to come
        PH_EXIT   = 2'd2    // last pass, or already exited
    } loop_phase_e;

    // Result of one branch execution
    typedef struct packed {
        logic taken;
        logic stage_en;
        logic dec_kernel;
        logic dec_drain;
    } br_result_t;

    function automatic loop_phase_e classify(input logic kc_zero,
                                             input logic dc_zero,
                                             input logic dc_one);
        if (!kc_zero)                 return PH_KERNEL;
        else if (!dc_zero && !dc_one) return PH_DRAIN;
        else                          return PH_EXIT;
    endfunction

    function automatic br_result_t resolve(input loop_phase_e ph,
                                           input logic dc_zero);
        br_result_t r;
        r = '0;
        unique case (ph)
            PH_KERNEL: begin
                r.taken      = 1'b1;
                r.stage_en   = 1'b1;
                r.dec_kernel = 1'b1;
            end
            PH_DRAIN: begin
                r.taken     = 1'b1;
                r.dec_drain = 1'b1;
            end
            default: begin
                // final pass: drain reaches zero unless it already is zero
                r.dec_drain = !dc_zero;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mlb_down_counter.sv
module mlb_down_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] init,
    input  logic          dec,
    output logic [CW-1:0] value,
    output logic          is_zero,
    output logic          is_one
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= init;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - ONE;
    end

    assign value   = cnt_q;
    assign is_zero = (cnt_q == '0);
    assign is_one  = (cnt_q == ONE);

    // R6: a counter at zero never wraps when asked to count down
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (value == '0 && dec && !load) |=> (value == '0));

    // R2: a load lands the init value
    a_r2_load_value: assert property (@(posedge clk) disable iff (rst)
        load |=> (value == $past(init)));

endmodule

// File: rtl/mlb_decide.sv
module mlb_decide (
    input  logic               kc_zero,
    input  logic               dc_zero,
    input  logic               dc_one,
    output mlb_pkg::br_result_t res
);
    import mlb_pkg::*;

    loop_phase_e phase;

    always_comb begin
        phase = classify(kc_zero, dc_zero, dc_one);
        res   = resolve(phase, dc_zero);
    end

    // R3: the stage bit and a kernel decrement go together
    always_comb begin
        a_r3_stage_with_kernel: assert (res.stage_en == res.dec_kernel);
    end

endmodule

// File: rtl/mlb_result.sv
module mlb_result (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               fire,
    input  mlb_pkg::br_result_t res,
    output logic               taken,
    output logic               stage_en,
    output logic               rotate,
    output logic               done
);
    logic taken_q, stage_q, rot_q, done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            taken_q <= 1'b0;
            stage_q <= 1'b0;
            rot_q   <= 1'b0;
        end else begin
            taken_q <= fire & res.taken;
            stage_q <= fire & res.stage_en;
            rot_q   <= fire;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            done_q <= 1'b0;
        else if (load)
            done_q <= 1'b0;
        else if (fire && !res.taken)
            done_q <= 1'b1;
    end

    assign taken    = taken_q;
    assign stage_en = stage_q;
    assign rotate   = rot_q;
    assign done     = done_q;

    // R7: taken and stage bit only appear with a rotate pulse
    a_r7_qualified: assert property (@(posedge clk) disable iff (rst)
        (taken || stage_en) |-> rotate);

    // R9: done holds until a load
    a_r9_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !load) |=> done);

endmodule

// File: rtl/mlb_ctrl.sv
module mlb_ctrl #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [CW-1:0] kc_init_i,
    input  logic [CW-1:0] dc_init_i,
    input  logic          br_i,
    output logic          taken_o,
    output logic          stage_en_o,
    output logic          rotate_o,
    output logic [CW-1:0] kc_o,
    output logic [CW-1:0] dc_o,
    output logic          done_o
);
    import mlb_pkg::*;

    logic       fire;
    logic       kc_zero, kc_one, dc_zero, dc_one;
    br_result_t res;

    // load has priority over a branch in the same cycle
    assign fire = br_i & ~load_i;

    mlb_down_counter #(.CW(CW)) u_kernel (
        .clk    (clk),
        .rst    (rst),
        .load   (load_i),
        .init   (kc_init_i),
        .dec    (fire & res.dec_kernel),
        .value  (kc_o),
        .is_zero(kc_zero),
        .is_one (kc_one)
    );

    mlb_down_counter #(.CW(CW)) u_drain (
        .clk    (clk),
        .rst    (rst),
        .load   (load_i),
        .init   (dc_init_i),
        .dec    (fire & res.dec_drain),
        .value  (dc_o),
        .is_zero(dc_zero),
        .is_one (dc_one)
    );

    mlb_decide u_decide (
        .kc_zero(kc_zero),
        .dc_zero(dc_zero),
        .dc_one (dc_one),
        .res    (res)
    );

    mlb_result u_result (
        .clk     (clk),
        .rst     (rst),
        .load    (load_i),
        .fire    (fire),
        .res     (res),
        .taken   (taken_o),
        .stage_en(stage_en_o),
        .rotate  (rotate_o),
        .done    (done_o)
    );

    // R3: kernel phase counts the kernel counter down, drain untouched
    a_r3_kernel_step: assert property (@(posedge clk) disable iff (rst)
        (br_i && !load_i && kc_o != '0) |=>
            (stage_en_o && taken_o && kc_o == CW'($past(kc_o) - 1'b1)
             && dc_o == $past(dc_o)));

    // R4: drain phase keeps the branch taken while more than one pass is left
    a_r4_drain_step: assert property (@(posedge clk) disable iff (rst)
        (br_i && !load_i && kc_o == '0 && dc_o > CW'(1)) |=>
            (!stage_en_o && taken_o && dc_o == CW'($past(dc_o) - 1'b1)));

    // R5: last drain pass falls through
    a_r5_exit: assert property (@(posedge clk) disable iff (rst)
        (br_i && !load_i && kc_o == '0 && kc_one == 1'b0 && dc_o == CW'(1)) |=>
            (!taken_o && rotate_o && dc_o == '0 && done_o));

    // R8: a load beside a branch gives no rotate
    a_r8_load_wins: assert property (@(posedge clk) disable iff (rst)
        load_i |=> !rotate_o);

    // R7: every rotate pulse traces back to a branch
    a_r7_rotate_source: assert property (@(posedge clk) disable iff (rst)
        rotate_o |-> $past(br_i && !load_i));

endmodule

// File: tb/mlb_ctrl_tb.sv
module mlb_ctrl_tb;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          load_i;
    logic [CW-1:0] kc_init_i, dc_init_i;
    logic          br_i;
    logic          taken_o, stage_en_o, rotate_o, done_o;
    logic [CW-1:0] kc_o, dc_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    mlb_ctrl #(.CW(CW)) u_dut (
        .clk(clk), .rst(rst), .load_i(load_i),
        .kc_init_i(kc_init_i), .dc_init_i(dc_init_i), .br_i(br_i),
        .taken_o(taken_o), .stage_en_o(stage_en_o), .rotate_o(rotate_o),
        .kc_o(kc_o), .dc_o(dc_o), .done_o(done_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // outputs after a branch or load: kc, dc, rotate, taken, stage, done
    task automatic chk_all(input string req, input int kc, input int dc,
                           input bit rot, input bit tk, input bit se, input bit dn);
        chk({req, " kc"},    kc_o, kc);
        chk({req, " dc"},    dc_o, dc);
        chk({req, " rot"},   rotate_o, rot);
        chk({req, " taken"}, taken_o, tk);
        chk({req, " stage"}, stage_en_o, se);
        chk({req, " done"},  done_o, dn);
    endtask

    task automatic do_load(input int kc, input int dc);
        @(negedge clk);
        load_i = 1; kc_init_i = CW'(kc); dc_init_i = CW'(dc);
        @(negedge clk);
        load_i = 0;
    endtask

    task automatic do_branch();
        @(negedge clk);
        br_i = 1;
        @(negedge clk);
        br_i = 0;
    endtask

    initial begin
        #1_600_000;
        errors++;
        $display("FAIL watchdog: actual 0 expected 1 (run ended)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; load_i = 0; br_i = 0; kc_init_i = '0; dc_init_i = '0;
        repeat (3) @(negedge clk);
        chk_all("R1 in reset", 0, 0, 0, 0, 0, 0);
        rst = 0;
        @(negedge clk);
        chk_all("R1 after reset", 0, 0, 0, 0, 0, 0);

        // R10: trip count 5, three stages
        do_load(4, 3);
        chk_all("R2 load 4/3", 4, 3, 0, 0, 0, 0);
        for (int k = 1; k <= 7; k++) begin
            int ekc, edc;
            ekc = (4 - k > 0) ? 4 - k : 0;
            edc = (k <= 4) ? 3 : 7 - k;
            do_branch();
            chk_all("R10 seq", ekc, edc, 1, k < 7, k <= 4, k == 7);
            chk("R7 gap rot", rotate_o, 1);
        end
        @(negedge clk);
        chk("R7 idle rot", rotate_o, 0);
        chk("R9 hold idle", done_o, 1);

        // sweep of small loads
        for (int kc0 = 0; kc0 <= 5; kc0++) begin
            for (int dc0 = 0; dc0 <= 4; dc0++) begin
                int ekc, edc;
                bit edone;
                do_load(kc0, dc0);
                chk_all("R2 sweep load", kc0, dc0, 0, 0, 0, 0);
                ekc = kc0; edc = dc0; edone = 0;
                while (!edone) begin
                    bit etk, ese;
                    if (ekc != 0) begin
                        ekc--; etk = 1; ese = 1;            // R3
                    end else if (edc > 1) begin
                        edc--; etk = 1; ese = 0;            // R4
                    end else begin
                        if (edc == 1) edc = 0;              // R5
                        etk = 0; ese = 0; edone = 1;        // R6 when dc was 0
                    end
                    do_branch();
                    if (ese)       chk_all("R3 sweep", ekc, edc, 1, etk, ese, edone);
                    else if (etk)  chk_all("R4 sweep", ekc, edc, 1, etk, ese, edone);
                    else           chk_all("R5 sweep exit", ekc, edc, 1, etk, ese, edone);
                    @(negedge clk);
                    chk("R7 gap", {rotate_o, taken_o, stage_en_o}, 0);
                end
                // R6: branch after exit, counters must not wrap
                do_branch();
                chk_all("R6 after exit", 0, 0, 1, 0, 0, 1);
            end
        end

        // R8: load and branch together
        do_load(2, 2);
        @(negedge clk);
        load_i = 1; br_i = 1; kc_init_i = CW'(7); dc_init_i = CW'(5);
        @(negedge clk);
        load_i = 0; br_i = 0;
        chk_all("R8 load wins", 7, 5, 0, 0, 0, 0);

        // R7: back-to-back branches, one pulse each
        @(negedge clk);
        br_i = 1;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            chk_all("R7 back-to-back", 7 - k, 5, 1, 1, 1, 0);
        end
        br_i = 0;
        @(negedge clk);
        chk("R7 after burst", rotate_o, 0);

        // R9: done clears on load, wide counter values
        do_load(0, 1);
        do_branch();
        chk_all("R9 exit", 0, 0, 1, 0, 0, 1);
        do_branch();
        chk("R9 hold", done_o, 1);
        do_load(65535, 65535);
        chk_all("R9 cleared R2 wide", 65535, 65535, 0, 0, 0, 0);
        do_branch();
        chk_all("R3 wide", 65534, 65535, 1, 1, 1, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule